// File: doc/BRIEF.md
# SPI Register-Window Burst Master

This block is a host-side SPI master for burst access to a peripheral's small register window. A request gives the direction, a byte address, a byte count, an SCLK divider and a lane-order option. The block builds one 16-bit command word from these fields and shifts it out. It then moves whole 16-bit data words. On a write, each word is taken from a valid/ready input stream. On a read, each received word goes out on a valid/ready output stream.

The command word and all of its data words travel inside one chip-select window. The link runs in SPI mode 0 with MSB-first shifting. When the link is byte-oriented, the option flag exchanges the two bytes of every 16-bit word on the wire. SCLK is divided down from the system clock, and the divider is clamped so that the link stays between 1 MHz and 52 MHz. If the receive holding register is still full, or the next write word has not arrived, the transfer pauses with SCLK low.

Top module: `spi_regwin_master`

## Requirements
- R1: Bit 15 of the command word is 1 for a read request and 0 for a write request.
- R2: Bits 14:12 of the command word equal bits 4:2 of the request's byte address.
- R3: Bits 11:0 of the command word hold the number of 16-bit words, which is the byte count divided by two with an odd count rounded up. Exactly that many data words follow the command word.
- R4: The link runs in mode 0. SCLK rests low whenever chip select is high. MOSI changes only while SCLK is low, MISO is captured on the rising SCLK edge, and MOSI carries zeros during the data words of a read.
- R5: With the lane option clear, every word, including the command word, is shifted bit 15 first. A received word is presented with its first wire bit in bit 15.
- R6: With the lane option set, every word, including the command word, goes out as {w[7:0], w[15:8]}, MSB first. Each received wire word is presented with its two bytes exchanged.
- R7: Chip select falls exactly once per request and stays low from the first command bit until after the last data bit.
- R8: Both the SCLK high time and the SCLK low time equal the divider input clamped to the range 1..50 system-clock cycles (100 MHz system clock, 1 to 52 MHz link).
- R9: The request is taken only while cmdReady is high, which happens only when the block is idle. busy rises on the cycle after acceptance and stays high until chip select is back high.
- R10: A received word is held on rxData with rxValid high until it is accepted. While the holding register is full at a read word boundary, or the next write word is missing, SCLK stays low and chip select stays asserted.
- R11: A byte count of zero sends the command word alone, with a zero length field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Request present |
| cmdReady | output | 1 | Request taken (idle) |
| cmdRead | input | 1 | 1 = read, 0 = write |
| cmdAddr | input | ADDR_W | Byte address inside the window |
| cmdBytes | input | LEN_W+1 | Byte count |
| cmdByteLanes | input | 1 | Exchange bytes of each word on the wire |
| cmdClkDiv | input | DIV_W | Requested SCLK half period in clk cycles |
| txValid | input | 1 | Write word present |
| txReady | output | 1 | Write word taken |
| txData | input | 16 | Write word |
| rxValid | output | 1 | Read word present |
| rxReady | input | 1 | Read word taken |
| rxData | output | 16 | Read word |
| busy | output | 1 | Request in progress |
| sclk | output | 1 | SPI clock |
| csN | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to peripheral |
| miso | input | 1 | Serial data from peripheral |

## Verification
A wrong word counter or a wrong bit counter shows up on the wire within a single word: a word is added or dropped, and the framing that the peripheral model decodes slips by whole bits. A lane-select or header-packing error corrupts the very first word after chip select falls. A divider or clamp error is visible on the first SCLK pulse of the request. A stall-logic fault shows as SCLK toggling, or as rxData changing, while a word is still unaccepted. The peripheral model catches this within the same word period.

// File: rtl/spi_regwin_pkg.sv
package spi_regwin_pkg;
  localparam int WORD_W = 16;
  localparam int LEN_W  = 12;   // length field of the command word

  typedef struct packed {
    logic loadHdr;   // build command word into shifter
    logic loadWord;  // load next data word (or zeros on read)
    logic shiftOut;  // advance MOSI on falling SCLK
    logic sampleIn;  // capture MISO on rising SCLK
    logic pushRx;    // move received word to holding register
  } dpStrobes_t;

  function automatic logic [WORD_W-1:0] laneSwap(input logic [WORD_W-1:0] w,
                                                 input logic en);
    return en ? {w[7:0], w[15:8]} : w;
  endfunction
endpackage

// File: rtl/spi_regwin_dp.sv
module spi_regwin_dp
  import spi_regwin_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        stb,
  input  logic              cmdRead,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              cmdByteLanes,
  input  logic [LEN_W-1:0]  hdrWords,
  input  logic [WORD_W-1:0] txData,
  input  logic              miso,
  output logic              mosi,
  output logic              rxValid,
  input  logic              rxReady,
  output logic [WORD_W-1:0] rxData
);
  logic [WORD_W-1:0] txSr, rxSr, rxHold;
  logic laneMode, readMode, rxValidQ;
  logic [WORD_W-1:0] hdrWord;

  assign hdrWord = {cmdRead, cmdAddr[4:2], hdrWords};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSr     <= '0;
      laneMode <= 1'b0;
      readMode <= 1'b0;
    end else if (stb.loadHdr) begin
      txSr     <= laneSwap(hdrWord, cmdByteLanes);
      laneMode <= cmdByteLanes;
      readMode <= cmdRead;
    end else if (stb.loadWord) begin
      txSr <= readMode ? '0 : laneSwap(txData, laneMode);
    end else if (stb.shiftOut) begin
      txSr <= {txSr[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSr <= '0;
    else if (stb.sampleIn) rxSr <= {rxSr[WORD_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHold   <= '0;
      rxValidQ <= 1'b0;
    end else if (stb.pushRx) begin
      rxHold   <= laneSwap(rxSr, laneMode);
      rxValidQ <= 1'b1;
    end else if (rxValidQ && rxReady) begin
      rxValidQ <= 1'b0;
    end
  end

  assign mosi    = txSr[WORD_W-1];
  assign rxValid = rxValidQ;
  assign rxData  = rxHold;

  // R10: an unaccepted read word stays put
  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData)));
endmodule

// File: rtl/spi_regwin_ctrl.sv
module spi_regwin_ctrl
  import spi_regwin_pkg::*;
#(
  parameter int SYS_HZ      = 100_000_000,
  parameter int SCLK_MIN_HZ = 1_000_000,
  parameter int SCLK_MAX_HZ = 52_000_000,
  parameter int DIV_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic             cmdRead,
  input  logic [LEN_W:0]   cmdBytes,
  input  logic [DIV_W-1:0] cmdClkDiv,
  input  logic             txValid,
  output logic             txReady,
  input  logic             rxFull,
  output logic [LEN_W-1:0] hdrWords,
  output dpStrobes_t       stb,
  output logic             sclk,
  output logic             csN,
  output logic             busy
);
  localparam int HALF_MIN_RAW = (SYS_HZ + 2*SCLK_MAX_HZ - 1) / (2*SCLK_MAX_HZ);
  localparam int HALF_MIN     = (HALF_MIN_RAW < 1) ? 1 : HALF_MIN_RAW;
  localparam int HALF_MAX     = SYS_HZ / (2*SCLK_MIN_HZ);
  localparam logic [DIV_W-1:0] HALF_LO = DIV_W'(HALF_MIN);
  localparam logic [DIV_W-1:0] HALF_HI = DIV_W'(HALF_MAX);

  typedef enum logic [1:0] {IDLE, SHIFT, WEND, HOLD} state_t;
  state_t state;

  logic [DIV_W-1:0] halfQ, tickCnt;
  logic [3:0]       bitCnt;
  logic [LEN_W-1:0] wordsLeft;
  logic isRead, isHdr, sclkQ, csNQ;
  logic tickDone, needPush, canGo;
  logic [LEN_W+1:0] bytesUp;

  function automatic logic [DIV_W-1:0] clampDiv(input logic [DIV_W-1:0] d);
    if (d < HALF_LO) return HALF_LO;
    if (d > HALF_HI) return HALF_HI;
    return d;
  endfunction

  assign bytesUp  = {1'b0, cmdBytes} + 1'b1;
  assign hdrWords = bytesUp[LEN_W:1];
  assign tickDone = (tickCnt == halfQ - 1'b1);
  assign needPush = !isHdr && isRead;
  assign canGo    = !(needPush && rxFull);

  always_comb begin
    stb      = '0;
    txReady  = 1'b0;
    cmdReady = (state == IDLE);
    unique case (state)
      IDLE:  stb.loadHdr = cmdValid;
      SHIFT: if (tickDone) begin
               if (!sclkQ) stb.sampleIn = 1'b1;
               else if (bitCnt != 4'd15) stb.shiftOut = 1'b1;
             end
      WEND:  if (canGo) begin
               stb.pushRx = needPush;
               if (wordsLeft != '0) begin
                 if (isRead) stb.loadWord = 1'b1;
                 else if (txValid) begin
                   stb.loadWord = 1'b1;
                   txReady      = 1'b1;
                 end
               end
             end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= IDLE;
      halfQ     <= HALF_LO;
      tickCnt   <= '0;
      bitCnt    <= '0;
      wordsLeft <= '0;
      isRead    <= 1'b0;
      isHdr     <= 1'b0;
      sclkQ     <= 1'b0;
      csNQ      <= 1'b1;
    end else begin
      unique case (state)
        IDLE: if (cmdValid) begin
          state     <= SHIFT;
          csNQ      <= 1'b0;
          halfQ     <= clampDiv(cmdClkDiv);
          wordsLeft <= hdrWords;
          isRead    <= cmdRead;
          isHdr     <= 1'b1;
          tickCnt   <= '0;
          bitCnt    <= '0;
        end
        SHIFT: if (tickDone) begin
          tickCnt <= '0;
          if (!sclkQ) sclkQ <= 1'b1;
          else begin
            sclkQ <= 1'b0;
            if (bitCnt == 4'd15) begin
              state  <= WEND;
              bitCnt <= '0;
            end else bitCnt <= bitCnt + 1'b1;
          end
        end else tickCnt <= tickCnt + 1'b1;
        WEND: if (canGo) begin
          if (wordsLeft == '0) begin
            state   <= HOLD;
            tickCnt <= '0;
          end else if (stb.loadWord) begin
            state     <= SHIFT;
            wordsLeft <= wordsLeft - 1'b1;
            isHdr     <= 1'b0;
            tickCnt   <= '0;
          end
        end
        HOLD: if (tickDone) begin
          csNQ  <= 1'b1;
          state <= IDLE;
        end else tickCnt <= tickCnt + 1'b1;
        default: state <= IDLE;
      endcase
    end
  end

  assign sclk = sclkQ;
  assign csN  = csNQ;
  assign busy = (state != IDLE);

  // R4: clock rests low outside the select window
  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  // R9: select low only while busy
  assert_busy_cs_R9: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);
  // R9: acceptance starts the transfer on the next cycle
  assert_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> (busy && !csN));
  // R10: a write word is only taken with the clock parked low
  assert_tx_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (!sclk && !csN));
endmodule

// File: rtl/spi_regwin_master.sv
module spi_regwin_master
  import spi_regwin_pkg::*;
#(
  parameter int SYS_HZ      = 100_000_000,
  parameter int SCLK_MIN_HZ = 1_000_000,
  parameter int SCLK_MAX_HZ = 52_000_000,
  parameter int ADDR_W      = 8,
  parameter int DIV_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdRead,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W:0]    cmdBytes,
  input  logic              cmdByteLanes,
  input  logic [DIV_W-1:0]  cmdClkDiv,
  input  logic              txValid,
  output logic              txReady,
  input  logic [15:0]       txData,
  output logic              rxValid,
  input  logic              rxReady,
  output logic [15:0]       rxData,
  output logic              busy,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  input  logic              miso
);
  dpStrobes_t       stb;
  logic [LEN_W-1:0] hdrWords;

  spi_regwin_ctrl #(
    .SYS_HZ(SYS_HZ), .SCLK_MIN_HZ(SCLK_MIN_HZ),
    .SCLK_MAX_HZ(SCLK_MAX_HZ), .DIV_W(DIV_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdRead(cmdRead), .cmdBytes(cmdBytes), .cmdClkDiv(cmdClkDiv),
    .txValid(txValid), .txReady(txReady), .rxFull(rxValid),
    .hdrWords(hdrWords), .stb(stb), .sclk(sclk), .csN(csN), .busy(busy)
  );

  spi_regwin_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdRead(cmdRead), .cmdAddr(cmdAddr),
    .cmdByteLanes(cmdByteLanes), .hdrWords(hdrWords), .txData(txData),
    .miso(miso), .mosi(mosi), .rxValid(rxValid), .rxReady(rxReady),
    .rxData(rxData)
  );

  // R4: MOSI holds still while SCLK is high
  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: tb/sim_spi_regwin_master.sv
module sim_spi_regwin_master;
  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 0, cmdRead = 0, cmdByteLanes = 0;
  logic [7:0] cmdAddr = '0, cmdClkDiv = '0;
  logic [12:0] cmdBytes = '0;
  logic txValid = 0, rxReady = 0, miso = 0;
  logic [15:0] txData = '0;
  logic cmdReady, txReady, rxValid, busy, sclk, csN, mosi;
  logic [15:0] rxData;

  spi_regwin_master u0 (.*);

  always #5 clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [15:0] expWire[$];
  string       expTag[$];
  logic [15:0] respQ[$];
  logic [15:0] expRx[$];
  logic [15:0] txQ[$];
  int csFalls = 0, halfErr = 0, busyErr = 0, expHalf = 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] swapIf(input logic [15:0] w, input bit en);
    return en ? {w[7:0], w[15:8]} : w;
  endfunction

  // peripheral model and wire scoreboard
  logic prevCs = 1, prevSclk = 0;
  logic [15:0] inSr = 0, respSr = 0;
  int sBits = 0, hiCnt = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevCs && !csN) begin
        csFalls++;
        sBits  = 0;
        respSr = (respQ.size() != 0) ? respQ.pop_front() : 16'h0;
        miso   = respSr[15];
      end
      if (!csN && !prevSclk && sclk) begin
        inSr = {inSr[14:0], mosi};
        sBits++;
        if (sBits == 16) begin
          sBits = 0;
          if (expWire.size() == 0) chk(0, "R3 extra word", {16'h0, inSr}, 32'h0);
          else begin
            logic [15:0] e;
            string t;
            e = expWire.pop_front();
            t = expTag.pop_front();
            chk(inSr == e, t, {16'h0, inSr}, {16'h0, e});
          end
        end
      end
      if (sclk) hiCnt++;
      if (prevSclk && !sclk) begin
        if (hiCnt != expHalf) halfErr++;
        hiCnt = 0;
        if (sBits == 0) respSr = (respQ.size() != 0) ? respQ.pop_front() : 16'h0;
        else respSr = respSr << 1;
        miso = respSr[15];
      end
      if (!csN && !busy) busyErr++;
      prevCs   = csN;
      prevSclk = sclk;
    end
  end

  // read-stream monitor
  always @(negedge clk) begin
    if (rstN && rxValid && rxReady) begin
      if (expRx.size() == 0) chk(0, "R10 unexpected rx word", {16'h0, rxData}, 32'h0);
      else begin
        logic [15:0] e;
        e = expRx.pop_front();
        chk(rxData == e, "R5 R6 rx word", {16'h0, rxData}, {16'h0, e});
      end
    end
  end

  task automatic runCmd(input bit rd, input logic [7:0] addr, input int bytes,
                        input logic [7:0] div, input bit bm, input int gap);
    int words;
    logic [15:0] hdr;
    logic [15:0] txw[$];
    words   = (bytes + 1) / 2;
    expHalf = (div < 1) ? 1 : ((div > 50) ? 50 : int'(div));
    csFalls = 0; halfErr = 0; busyErr = 0;
    hdr = {rd, addr[4:2], 12'(words)};
    expWire.push_back(swapIf(hdr, bm));
    expTag.push_back("R1 R2 R3 header");
    txw = txQ;
    for (int i = 0; i < words; i++) begin
      expWire.push_back(rd ? 16'h0 : swapIf(txw[i], bm));
      expTag.push_back(rd ? "R4 read mosi zero" : (bm ? "R6 tx word" : "R5 tx word"));
    end
    @(posedge clk); #1;
    cmdValid = 1; cmdRead = rd; cmdAddr = addr; cmdBytes = 13'(bytes);
    cmdClkDiv = div; cmdByteLanes = bm;
    fork
      begin
        do @(negedge clk); while (!cmdReady);
        @(posedge clk); #1;
        cmdValid = 0;
      end
      if (!rd) begin
        for (int i = 0; i < words; i++) begin
          if (i == 1 && gap > 0) begin
            repeat (gap / 2) @(negedge clk);
            chk(!sclk && !csN, "R10 tx stall", {30'h0, sclk, csN}, 32'h0);
            repeat (gap / 2) @(posedge clk);
            #1;
          end
          txValid = 1; txData = txw[i];
          do @(negedge clk); while (!txReady);
          @(posedge clk); #1;
          txValid = 0;
        end
      end
    join
    do @(negedge clk); while (busy || !csN);
    repeat (3) @(negedge clk);
    chk(csFalls == 1, "R7 single select", csFalls, 1);
    chk(expWire.size() == 0, "R3 word count", expWire.size(), 0);
    chk(halfErr == 0, "R8 sclk half period", halfErr, 0);
    chk(busyErr == 0, "R9 busy during select", busyErr, 0);
    chk(cmdReady && !sclk, "R9 idle after end", {30'h0, cmdReady, sclk}, 32'h2);
    txQ.delete();
  endtask

  task automatic readSetup(input logic [15:0] v0, input logic [15:0] v1,
                           input logic [15:0] v2, input int n, input bit bm);
    logic [15:0] v[3];
    v[0] = v0; v[1] = v1; v[2] = v2;
    respQ.push_back(16'h5A5A);   // returned during command word, discarded
    for (int i = 0; i < n; i++) begin
      respQ.push_back(swapIf(v[i], bm));
      expRx.push_back(v[i]);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    chk(csN && !sclk && !busy && !rxValid && cmdReady, "R9 reset state",
        {27'h0, csN, sclk, busy, rxValid, cmdReady}, 32'h11);

    // 16-bit write, index 3
    txQ = '{16'hA5C3, 16'h1234};
    runCmd(0, 8'h0C, 4, 8'd3, 0, 0);

    // 16-bit read, index 5, fastest divider
    rxReady = 1;
    readSetup(16'hC0DE, 16'h8001, 16'h7FFE, 3, 0);
    runCmd(1, 8'h14, 6, 8'd1, 0, 0);
    chk(expRx.size() == 0, "R5 all read words", expRx.size(), 0);

    // odd byte count, byte lanes, index 7, divider clamped up (R8)
    txQ = '{16'h0102, 16'hF00D, 16'hABCD};
    runCmd(0, 8'h1F, 5, 8'd0, 1, 0);

    // byte-lane read, divider clamped down, holding register stalls
    rxReady = 0;
    readSetup(16'hBEEF, 16'h0123, 16'h0, 2, 1);
    fork
      runCmd(1, 8'h04, 4, 8'd200, 1, 0);
      begin
        repeat (5500) @(negedge clk);
        chk(!sclk && !csN && rxValid, "R10 rx stall",
            {29'h0, sclk, csN, rxValid}, 32'h1);
        chk(rxData == 16'hBEEF, "R10 rx held", {16'h0, rxData}, 32'hBEEF);
        @(posedge clk); #1;
        rxReady = 1;
      end
    join
    chk(expRx.size() == 0, "R6 all read words", expRx.size(), 0);

    // zero length: command word only
    runCmd(0, 8'h04, 0, 8'd5, 0, 0);
    chk(!rxValid, "R11 no data moved", {31'h0, rxValid}, 32'h0);

    // write with late second word
    txQ = '{16'h5555, 16'hAAAA};
    runCmd(0, 8'h08, 4, 8'd2, 0, 200);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule